// File: doc/BRIEF.md
# Decoder Register Configuration Sequencer

This block is a write-only I2C master that loads a video decoder's registers. It holds one fixed script of register writes for each video input channel. It plays the script for the selected channel back over the bus, with one bus transaction per entry. Each transaction is a start condition, the device-address byte, a register sub-address byte, a data byte and a stop condition. After every byte the master releases SDA and samples the slave's acknowledge.

The script plays automatically when reset is released. It plays again whenever the channel selection changes to another legal channel, or when the reload strobe is pulsed. A selection change that arrives while a script is running is held until the current transaction has sent its stop. The new channel's script then starts over from its first entry. A missing acknowledge ends the current transaction early with a stop and sets a sticky error flag. The sequencer then moves on to the next entry.

SDA and SCL are open-drain. Each port `*_oe` pulls its line low when it is 1, and the line floats high when it is 0. The SCL rate comes from a divider on the system clock.

Top module: `i2c_cfg_seq`

## Requirements
- R1: When reset is released, the block sends the full script for the channel on `chan_sel` without any strobe. The script is 16 writes. Each write is a start, the address byte 0x40, the sub-address byte, the data byte and a stop.
- R2: For channel c and entry i (0..15), the sub-address is 0x20 + i and the data is (c*16 + i) XOR 0xC3. Entries go out in ascending i.
- R3: One SCL period is 4*DIV system clocks, where DIV = CLK_HZ / (4*SCL_HZ). Inside a transaction, SDA changes only while SCL is low. The two exceptions are the start (SDA falls while SCL is high) and the stop (SDA rises while SCL is high).
- R4: On the ninth clock of every byte the master releases SDA. A low level sampled there counts as an acknowledge, and the master goes on to the next byte.
- R5: A high level on an acknowledge clock sets `ack_err`. The master sends a stop right after that clock, without sending the remaining bytes, and continues with the next entry. `ack_err` stays set until reset.
- R6: A change of `chan_sel` to another legal channel while the block is idle starts that channel's script.
- R7: A change of `chan_sel` during a transaction lets that transaction finish with its stop. The script then restarts at entry 0 of the new channel, and the old script is not completed.
- R8: A one-clock pulse on `start` replays the script of the current channel. If the pulse arrives during a script, the replay begins after the current transaction.
- R9: `done` is a single-clock pulse issued only when the last entry's stop has been sent. `busy` is high while a script runs and is low when `done` pulses.
- R10: Values of `chan_sel` of 6 or more are ignored. They start nothing, and the channel in use is not changed.
- R11: While the block is idle and during reset, neither line is pulled low. Reset clears `ack_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_sel | input | 3 | Selected video input channel |
| start | input | 1 | Reload strobe, one clock wide |
| sda_i | input | 1 | Level of the SDA line |
| sda_oe | output | 1 | Pull SDA low when 1 |
| scl_oe | output | 1 | Pull SCL low when 1 |
| busy | output | 1 | Script in progress |
| done | output | 1 | Pulse after the last entry's stop |
| ack_err | output | 1 | Sticky missing-acknowledge flag |

## Verification
The bench attaches a bus slave model that decodes starts, stops and bytes and acknowledges each byte. Scripts are played after reset, after an idle channel change, after a reload strobe and after an illegal selection. Comparing the logged bytes against the table formula separates correct channel selection from a stale channel, and correct entry ordering from a skipped or repeated entry. A channel change placed inside the third transaction shows whether the current transaction completes and whether the restart begins at entry 0. A slave that refuses the sub-address byte of one entry shows whether the transaction is cut short after two bytes while the remaining entries still go out.

// File: rtl/i2c_cfg_seq.sv
`timescale 1ns/1ps
module i2c_cfg_seq #(
  parameter int CLK_HZ = 50_000_000,
  parameter int SCL_HZ = 100_000,
  parameter int NCH = 6,
  parameter int NREG = 16,
  parameter logic [7:0] DEV_ADDR = 8'h40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [$clog2(NCH)-1:0] chan_sel,
  input  logic start,
  input  logic sda_i,
  output logic sda_oe,
  output logic scl_oe,
  output logic busy,
  output logic done,
  output logic ack_err
);
  localparam int DIV = CLK_HZ / (4 * SCL_HZ);
  localparam int CW  = $clog2(DIV + 1);
  localparam int EW  = $clog2(NREG);
  localparam int CHW = $clog2(NCH);

  typedef enum logic [1:0] {S_IDLE, S_START, S_BIT, S_STOP} st_t;

  function automatic logic [15:0] rom_word(input logic [CHW-1:0] c, input logic [EW-1:0] i);
    logic [7:0] s, d;
    s = 8'h20 + 8'(i);
    d = 8'({c, i}) ^ 8'hC3;
    return {s, d};
  endfunction

  st_t st;
  logic [CW-1:0] cnt;
  logic [1:0] ph, byten;
  logic [3:0] bitn;
  logic [EW-1:0] entry;
  logic [CHW-1:0] ch;
  logic [7:0] sh;
  logic pend, nak;

  wire tick  = (cnt == CW'(DIV - 1));
  wire valid = {1'b0, chan_sel} < (CHW+1)'(NCH);
  wire req   = start | (valid & (chan_sel != ch));
  wire [15:0] word = rom_word(ch, entry);

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else cnt <= tick ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= '0; bitn <= '0; byten <= '0; entry <= '0;
      ch <= '0; sh <= '0; pend <= 1'b1; nak <= 1'b0;
      sda_oe <= 1'b0; scl_oe <= 1'b0; ack_err <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (req) pend <= 1'b1;
      if (tick) begin
        if (st != S_IDLE) ph <= ph + 1'b1;
        case (st)
          S_IDLE: if (pend) begin
            st <= S_START; ph <= '0; entry <= '0; pend <= 1'b0;
            if (valid) ch <= chan_sel;
          end
          S_START: case (ph)
            2'd0: begin sda_oe <= 1'b0; scl_oe <= 1'b0; end
            2'd1: sda_oe <= 1'b1;
            2'd2: scl_oe <= 1'b1;
            default: begin
              st <= S_BIT; bitn <= '0; byten <= '0; sh <= DEV_ADDR; nak <= 1'b0;
            end
          endcase
          S_BIT: case (ph)
            2'd0: sda_oe <= (bitn == 4'd8) ? 1'b0 : ~sh[7];
            2'd1: scl_oe <= 1'b0;
            2'd2: if (bitn == 4'd8 && sda_i) begin nak <= 1'b1; ack_err <= 1'b1; end
            default: begin
              scl_oe <= 1'b1;
              if (bitn == 4'd8) begin
                if (nak || byten == 2'd2) st <= S_STOP;
                else begin
                  byten <= byten + 1'b1;
                  bitn <= '0;
                  sh <= (byten == 2'd0) ? word[15:8] : word[7:0];
                end
              end else begin
                bitn <= bitn + 1'b1;
                sh <= {sh[6:0], 1'b0};
              end
            end
          endcase
          S_STOP: case (ph)
            2'd0: sda_oe <= 1'b1;
            2'd1: scl_oe <= 1'b0;
            2'd2: sda_oe <= 1'b0;
            default: begin
              if (pend) begin
                st <= S_START; entry <= '0; pend <= 1'b0;
                if (valid) ch <= chan_sel;
              end else if (entry == EW'(NREG - 1)) begin
                st <= S_IDLE; done <= 1'b1;
              end else begin
                st <= S_START; entry <= entry + 1'b1;
              end
            end
          endcase
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_cfg_seq_chk.sv
`timescale 1ns/1ps
module i2c_cfg_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic ack_err,
  input logic sda_oe,
  input logic scl_oe
);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n) ack_err |=> ack_err);
  p_idle_released_r11: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (!sda_oe && !scl_oe));
  p_sda_scl_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe))) |-> busy);
endmodule

bind i2c_cfg_seq i2c_cfg_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .ack_err(ack_err), .sda_oe(sda_oe), .scl_oe(scl_oe)
);

// File: tb/sim_i2c_cfg_seq.sv
`timescale 1ns/1ps
module sim_i2c_cfg_seq;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0] chan_sel = 3'd0;
  logic sda_oe, scl_oe, busy, done, ack_err;
  logic slv_drv = 1'b0;
  wire scl_l = ~scl_oe;
  wire sda_l = ~(sda_oe | slv_drv);

  always #2.5 clk = ~clk;

  i2c_cfg_seq #(.CLK_HZ(800), .SCL_HZ(100)) u0 (
    .clk(clk), .rst_n(rst_n), .chan_sel(chan_sel), .start(start), .sda_i(sda_l),
    .sda_oe(sda_oe), .scl_oe(scl_oe), .busy(busy), .done(done), .ack_err(ack_err));

  int checks = 0, errors = 0, finished = 0;
  logic [7:0] lg_b [0:127][0:2];
  int lg_nb [0:127];
  int nlog = 0, ndone = 0, nb = 0, bitc = 0, cyc = 0, last_rise = -1, pmin = 9999, pmax = 0;
  logic [7:0] cur [0:2];
  logic [7:0] sh = 8'h00;
  logic in_x = 1'b0, pscl = 1'b1, psda = 1'b1, nack_on = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (done) ndone++;
    if (!rst_n) begin
      in_x = 1'b0; slv_drv = 1'b0;
    end else if (pscl && scl_l && psda && !sda_l) begin
      in_x = 1'b1; bitc = 0; nb = 0; last_rise = -1;
    end else if (in_x && pscl && scl_l && !psda && sda_l) begin
      lg_nb[nlog] = nb;
      for (int k = 0; k < 3; k++) lg_b[nlog][k] = cur[k];
      nlog++; in_x = 1'b0;
    end else if (in_x && !pscl && scl_l) begin
      if (last_rise >= 0) begin
        if (cyc - last_rise < pmin) pmin = cyc - last_rise;
        if (cyc - last_rise > pmax) pmax = cyc - last_rise;
      end
      last_rise = cyc;
      if (bitc < 8) begin
        sh = {sh[6:0], sda_l};
        if (bitc == 7 && nb < 3) begin cur[nb] = sh; nb++; end
        bitc++;
      end else bitc = 0;
    end else if (in_x && pscl && !scl_l) begin
      if (bitc == 8) slv_drv = !(nack_on && nb == 2 && cur[1] == 8'h24);
      else slv_drv = 1'b0;
    end
    pscl = scl_l; psda = sda_l;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_done();
    int d0 = ndone;
    for (int i = 0; i < 20000 && ndone == d0; i++) @(negedge clk);
  endtask

  task automatic check_entries(input string req, input int base, input int ch, input int first, input int n);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      int e = first + i;
      if (lg_nb[base+i] != 3 || lg_b[base+i][0] != 8'h40 ||
          lg_b[base+i][1] != 8'(8'h20 + e) || lg_b[base+i][2] != 8'((ch*16 + e) ^ 'hC3)) bad++;
    end
    chk(req, bad, 0);
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    chk("R11 reset sda", int'(sda_oe), 0);
    chk("R11 reset scl", int'(scl_oe), 0);
    chk("R11 reset err", int'(ack_err), 0);
    chk("R9 reset done", int'(done), 0);
  endtask

  task automatic t_boot();
    rst_n = 1'b1;
    repeat (100) @(negedge clk);
    chk("R9 busy during script", int'(busy), 1);
    wait_done();
    repeat (2) @(negedge clk);
    chk("R1 write count", nlog, 16);
    check_entries("R1 R2 R4 boot ch0", 0, 0, 0, 16);
    chk("R9 one done", ndone, 1);
    chk("R9 idle after done", int'(busy), 0);
    chk("R3 scl period min", pmin, 8);
    chk("R3 scl period max", pmax, 8);
  endtask

  task automatic t_switch_idle();
    int base = nlog;
    chan_sel = 3'd3;
    wait_done();
    repeat (2) @(negedge clk);
    chk("R6 count", nlog - base, 16);
    check_entries("R6 ch3", base, 3, 0, 16);
  endtask

  task automatic t_mid();
    int base = nlog, d0;
    d0 = ndone;
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    for (int i = 0; i < 5000 && nlog < base + 2; i++) @(negedge clk);
    for (int i = 0; i < 5000 && !in_x; i++) @(negedge clk);
    repeat (20) @(negedge clk);
    chan_sel = 3'd5;
    wait_done();
    repeat (2) @(negedge clk);
    chk("R7 count", nlog - base, 19);
    check_entries("R7 R8 old channel finished", base, 3, 0, 3);
    check_entries("R7 new channel from 0", base + 3, 5, 0, 16);
    chk("R7 single done", ndone - d0, 1);
  endtask

  task automatic t_invalid();
    int base = nlog;
    chan_sel = 3'd7;
    repeat (300) @(negedge clk);
    chk("R10 no start", int'(busy), 0);
    chk("R10 no writes", nlog - base, 0);
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done();
    repeat (2) @(negedge clk);
    chk("R8 strobe count", nlog - base, 16);
    check_entries("R8 R10 keeps ch5", base, 5, 0, 16);
  endtask

  task automatic t_nack();
    int base = nlog, bad = 0;
    nack_on = 1'b1;
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done();
    repeat (2) @(negedge clk);
    nack_on = 1'b0;
    chk("R5 count", nlog - base, 16);
    chk("R5 err set", int'(ack_err), 1);
    chk("R5 cut short", lg_nb[base+4], 2);
    chk("R5 refused byte", int'(lg_b[base+4][1]), 'h24);
    check_entries("R5 before", base, 5, 0, 4);
    check_entries("R5 after", base + 5, 5, 5, 11);
    repeat (50) @(negedge clk);
    chk("R5 sticky", int'(ack_err), 1);
    if (bad != 0) chk("R5", bad, 0);
  endtask

  task automatic t_reset_clear();
    int base;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R11 err cleared", int'(ack_err), 0);
    chk("R11 lines released", int'(sda_oe | scl_oe), 0);
    base = nlog;
    rst_n = 1'b1;
    wait_done();
    repeat (2) @(negedge clk);
    chk("R1 R10 reboot ch0", nlog - base, 16);
    check_entries("R1 reboot entries", base, 0, 0, 16);
  endtask

  initial begin
    t_reset();
    t_boot();
    t_switch_idle();
    t_mid();
    t_invalid();
    t_nack();
    t_reset_clear();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule